// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers four interrupt events into one interrupt request for the CPU. The events are a video line (raster) event and three sound DMA channel events. Each event sets a pending flag. The request output stays high while any flag is set. When the CPU runs an interrupt acknowledge cycle, the block picks the pending source with the highest priority. It then latches an 8-bit vector made from a base value that software programs and a 2-bit code for that source, and clears the flags that the acknowledge is meant to retire.

Software reaches three registers through a small port:
- **Vector register.** Holds the vector base. Its bit 0 chooses whether DMA flags clear themselves on acknowledge.
- **Status/control register.** Shows which DMA channels are pending and whether the last acknowledge served the raster source. Writing 1 to a DMA bit clears that channel.
- **Mode register.** Only its raster-clear bit is implemented.

Register reads are combinational from the select input. Writes take effect at the next clock edge.

Top module: `ivec_ctrl`

## Requirements
- R1: After reset the vector register reads 0x01, the status register reads 0x00 and `irq_o` is low.
- R2: A set pulse on any source raises `irq_o` at the next clock edge. `irq_o` stays high while at least one flag is pending and falls once all flags are clear.
- R3: Acknowledge serves one source by fixed priority: raster (set index 3) first, then DMA 2 (index 2), then DMA 1 (index 1), then DMA 0 (index 0).
- R4: The vector is made up as follows:
  - bits 7..3 are bits 7..3 of the vector register;
  - bits 2..1 are the source code: 00 = DMA 2, 01 = DMA 1, 10 = DMA 0, 11 = raster;
  - bit 0 is always 0, whatever vector register bit 0 holds.
- R5: An acknowledge that serves the raster source always clears its flag and sets status bit 7. An acknowledge that serves a DMA source clears status bit 7.
- R6: When vector register bit 0 is 0, an acknowledge clears the flag of the DMA channel it serves. When that bit is 1, the flag stays set.
- R7: Status bits 6, 5 and 4 read as the pending flags of DMA 0, 1 and 2. Writing 1 to one of these bits clears that flag. Writing 0 to it has no effect.
- R8: Writing 1 to bit 4 of the mode register clears a pending raster flag. Writing 0 there leaves the flag set.
- R9: When a set pulse and a clear reach the same flag in the same cycle, the flag ends up set.
- R10: An acknowledge with nothing pending drives the raster code (11) and changes no flag and no status bit.
- R11: The vector is captured in the first cycle of `ack_i`. It stays fixed while `ack_i` is held high, even if a new source arrives during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | 4 | Set pulses: [0] DMA 0, [1] DMA 1, [2] DMA 2, [3] raster |
| wr_en | input | 1 | Register write strobe |
| sel | input | 2 | Register select: 0 vector, 1 status/control, 2 mode |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| ack_i | input | 1 | Interrupt acknowledge, high for the whole cycle |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Latched interrupt vector |

## Verification
Flags, status bits and `irq_o` all change at the first clock edge after a set pulse or a register write. The bench therefore drives inputs just after a falling edge and samples at the following falling edge, which is one edge later. The vector is registered at the edge where `ack_i` is first seen high. It is checked at the next falling edge, and again one full cycle later with `ack_i` still high to confirm it holds. Combinational reads are sampled a short delay after `sel` settles, away from any edge.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    localparam int NSRC   = 4;
    localparam int DATA_W = 8;
    localparam int CODE_W = 2;
    localparam int SRC_RASTER = NSRC - 1;
    localparam int NDMA       = NSRC - 1;

    // register bit positions that software and this block agree on
    localparam int VEC_MANUAL_BIT = 0;
    localparam int STAT_LAST_BIT  = 7;
    localparam int STAT_DMA0_BIT  = 6;   // DMA k sits at STAT_DMA0_BIT - k
    localparam int MODE_RCLR_BIT  = 4;

    typedef enum logic [1:0] {
        SEL_VEC  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MODE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
        logic [NSRC-1:0]   grant;
    } arb_t;

    // source index to vector code: raster -> 11, DMA k -> 2 - k
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        if (idx == SRC_RASTER) return '1;
        return CODE_W'(NDMA - 1 - idx);
    endfunction
endpackage

// File: rtl/ivec_pending.sv
module ivec_pending
    import ivec_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)           pend_o[k] <= 1'b0;
            else if (set_i[k]) pend_o[k] <= 1'b1;
            else if (clr_i[k]) pend_o[k] <= 1'b0;
        end

        // R9: a set always lands, even against a clear
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> pend_o[k]);

        p_clear_drops_r7: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !pend_o[k]);
    end
endmodule

// File: rtl/ivec_arbiter.sv
module ivec_arbiter
    import ivec_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    output arb_t            res_o
);
    always_comb begin
        res_o = '{hit: 1'b0, code: '1, grant: '0};
        // ascending scan: a higher index overrides, giving it priority
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i]) begin
                res_o.hit   = 1'b1;
                res_o.code  = src_code(i);
                res_o.grant = '0;
                res_o.grant[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (!$isunknown(pend_i)) begin
            p_grant_single_r3: assert ($onehot0(res_o.grant));
            p_raster_first_r3: assert (!pend_i[SRC_RASTER] || res_o.grant[SRC_RASTER]);
            p_grant_pending_r3: assert ((res_o.grant & ~pend_i) == '0);
        end
    end
endmodule

// File: rtl/ivec_ctrl.sv
module ivec_ctrl
    import ivec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   set_i,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] vec_o
);
    localparam int BASE_LSB = CODE_W + 1;

    logic [DATA_W-1:0] vec_reg;
    logic              last_raster;
    logic              ack_q;
    logic [DATA_W-1:0] vec_q;
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   clr;
    arb_t              arb;
    logic              ack_start;
    logic              auto_clr;
    reg_sel_e          rsel;

    assign rsel      = reg_sel_e'(sel);
    assign ack_start = ack_i && !ack_q;
    assign auto_clr  = !vec_reg[VEC_MANUAL_BIT];

    ivec_arbiter u_arb (
        .pend_i (pend),
        .res_o  (arb)
    );

    // clear requests per source
    for (genvar k = 0; k < NDMA; k++) begin : g_dma_clr
        assign clr[k] = (wr_en && rsel == SEL_STAT && wr_data[STAT_DMA0_BIT - k])
                      || (ack_start && arb.grant[k] && auto_clr);
    end
    assign clr[SRC_RASTER] = (wr_en && rsel == SEL_MODE && wr_data[MODE_RCLR_BIT])
                           || (ack_start && arb.grant[SRC_RASTER]);

    ivec_pending #(.N(NSRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_reg     <= DATA_W'(1) << VEC_MANUAL_BIT;
            last_raster <= 1'b0;
            ack_q       <= 1'b0;
            vec_q       <= '0;
        end else begin
            ack_q <= ack_i;
            if (wr_en && rsel == SEL_VEC) vec_reg <= wr_data;
            if (ack_start) begin
                vec_q <= {vec_reg[DATA_W-1:BASE_LSB], arb.code, 1'b0};
                if (arb.hit) last_raster <= arb.grant[SRC_RASTER];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_VEC: rd_data = vec_reg;
            SEL_STAT: begin
                rd_data[STAT_LAST_BIT] = last_raster;
                for (int k = 0; k < NDMA; k++) rd_data[STAT_DMA0_BIT - k] = pend[k];
            end
            default: rd_data = '0;
        endcase
    end

    assign irq_o = |pend;
    assign vec_o = vec_q;

    // R2: any arriving event requests service at the next edge
    p_irq_follows_set_r2: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> irq_o);

    // R4: a pending raster is always served with code 11
    p_raster_code_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_start && pend[SRC_RASTER]) |=> (vec_o[CODE_W:1] == '1 && !vec_o[0]));

    // R5: raster acknowledged always retires and marks status
    p_raster_retire_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_start && pend[SRC_RASTER] && !set_i[SRC_RASTER]) |=> (!pend[SRC_RASTER] && last_raster));

    // R6: in manual mode the served DMA 0 flag survives the acknowledge
    p_manual_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_start && !auto_clr && pend[0] && !(wr_en && rsel == SEL_STAT)) |=> pend[0]);

    // R11: vector frozen while acknowledge is held
    p_vec_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (ack_i && ack_q) |=> $stable(vec_o));
endmodule

// File: tb/sim_ivec_ctrl.sv
module sim_ivec_ctrl;
    import ivec_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] set_i;
    logic       wr_en;
    logic [1:0] sel;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       ack_i;
    logic       irq_o;
    logic [7:0] vec_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ivec_ctrl u0 (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_i),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ack_i   (ack_i),
        .irq_o   (irq_o),
        .vec_o   (vec_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; sel = s; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        sel = s;
        #0.5;
        d = rd_data;
    endtask

    task automatic pulse(input logic [3:0] m);
        set_i = m;
        step();
        set_i = '0;
    endtask

    // one acknowledge of two cycles; returns the vector seen in its first cycle
    task automatic ack(output logic [7:0] v);
        ack_i = 1'b1;
        step();
        v = vec_o;
        step();
        ack_i = 1'b0;
        step();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(SEL_VEC, d);  check("R1 vector reg", d, 8'h01);
        rd(SEL_STAT, d); check("R1 status", d, 8'h00);
        check("R1 irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_priority_manual();
        logic [7:0] v, d;
        wr(SEL_VEC, 8'hA9);
        pulse(4'b1111);
        check("R2 irq raised", {7'b0, irq_o}, 8'h01);
        rd(SEL_STAT, d); check("R7 all dma flags", d, 8'h70);
        ack(v); check("R3 R4 raster first", v, 8'hAE);
        rd(SEL_STAT, d); check("R5 raster served bit7", d, 8'hF0);
        ack(v); check("R3 R4 dma2 next", v, 8'hA8);
        rd(SEL_STAT, d); check("R5 R6 manual keeps dma2, bit7 low", d, 8'h70);
        wr(SEL_STAT, 8'h10);
        rd(SEL_STAT, d); check("R7 clear dma2", d, 8'h60);
        ack(v); check("R4 dma1 code", v, 8'hAA);
        wr(SEL_STAT, 8'h20);
        ack(v); check("R4 dma0 code", v, 8'hAC);
        wr(SEL_STAT, 8'h00);
        rd(SEL_STAT, d); check("R7 zero write no effect", d, 8'h40);
        wr(SEL_STAT, 8'h40);
        check("R2 irq falls", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_autoclear();
        logic [7:0] v, d;
        wr(SEL_VEC, 8'h50);
        pulse(4'b0011);
        ack(v); check("R6 auto dma1 vector", v, 8'h52);
        rd(SEL_STAT, d); check("R6 dma1 auto cleared", d, 8'h40);
        ack(v); check("R6 auto dma0 vector", v, 8'h54);
        check("R6 R2 irq low after autoclear", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_mode_clear();
        pulse(4'b1000);
        wr(SEL_MODE, 8'h00);
        check("R8 zero mode write keeps raster", {7'b0, irq_o}, 8'h01);
        wr(SEL_MODE, 8'h10);
        check("R8 mode bit4 clears raster", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        wr(SEL_VEC, 8'h51);
        set_i = 4'b0001;
        wr(SEL_STAT, 8'h40);
        set_i = '0;
        rd(SEL_STAT, d); check("R9 set beats clear", d, 8'h40);
        set_i = 4'b1000;
        wr(SEL_MODE, 8'h10);
        set_i = '0;
        check("R9 raster set beats mode clear", {7'b0, irq_o}, 8'h01);
        wr(SEL_MODE, 8'h10);
        wr(SEL_STAT, 8'h40);
    endtask

    task automatic t_empty_ack();
        logic [7:0] v, d;
        wr(SEL_VEC, 8'h50);
        pulse(4'b1000);
        ack(v);
        ack(v); check("R10 empty ack raster code", v, 8'h56);
        rd(SEL_STAT, d); check("R10 status unchanged", d, 8'h80);
        check("R10 irq stays low", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] v, d;
        wr(SEL_VEC, 8'h51);
        pulse(4'b0001);
        ack_i = 1'b1;
        step();
        v = vec_o; check("R11 first vector", v, 8'h54);
        set_i = 4'b1000;
        step();
        set_i = '0;
        check("R11 vector held", vec_o, 8'h54);
        step();
        check("R11 vector still held", vec_o, 8'h54);
        ack_i = 1'b0;
        step();
        rd(SEL_STAT, d); check("R11 dma0 still pending", d, 8'h40);
        check("R11 raster pending", {7'b0, irq_o}, 8'h01);
        wr(SEL_MODE, 8'h10);
        wr(SEL_STAT, 8'h40);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; set_i = '0; wr_en = 1'b0; sel = '0; wr_data = '0; ack_i = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_priority_manual();
        t_autoclear();
        t_mode_clear();
        t_set_wins();
        t_empty_ack();
        t_latch();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule